// File: doc/BRIEF.md
# Barrel Thread Slot Scheduler

This block chooses, on every clock cycle, which hardware thread context may issue one instruction into a single-issue pipeline that has no bypass network. It has three run-time scheduling modes. The first is a fixed rotation over all threads. The second is a rotation through a software-written table of issue slots. The third is a ready-driven round-robin pick among the threads that can go. In the two rotating modes, an owner that is not ready costs a pipeline bubble. Its slot is never handed to another thread, so the spacing between instructions of one thread stays fixed.

The outputs are an issue-valid flag, the issuing thread identifier and a bubble flag. Downstream stages carry the identifier with the instruction so that each stage reads and writes the state of the correct thread. With four threads rotating on a five-stage pipe, two instructions of the same thread are never close enough to need an interlock.

The scheduler is a three-state machine: `ST_FIXED`, `ST_TABLE` and `ST_READY`. It leaves a state only at a commit point. In `ST_FIXED` the commit point is the last step of the thread rotation. In `ST_TABLE` it is the last table slot. In `ST_READY` every cycle is a commit point. At a commit point the machine takes the transition selected by `mode_sel`: code 0 goes to `ST_FIXED`, code 1 goes to `ST_TABLE`, code 2 goes to `ST_READY`, and code 3 is treated as code 0. Table writes land in a shadow copy, and that copy is moved into the active table at the same commit point.

Top module: `barrel_issue_sched`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) has these effects:
  - it selects `ST_FIXED`;
  - it zeroes the rotation pointer and the slot pointer;
  - it marks every shadow and active table entry invalid;
  - it sets the last-issued thread to NUM_THREADS-1.
  The first cycle after reset therefore offers its slot to thread 0.
- R2: In `ST_FIXED`, the k-th cycle after the state is entered offers its slot to thread k mod NUM_THREADS. The thread issues (`issue_valid`=1, `issue_tid`=thread) when its `thread_ready` bit is 1.
- R3: In `ST_FIXED`, if the slot owner is not ready, the cycle is a bubble (`issue_valid`=0, `bubble`=1). No other thread issues in that cycle, even if it is ready.
- R4: In `ST_TABLE`, the slot pointer steps through entries 0 to NUM_SLOTS-1 cyclically, one entry per cycle. The thread named by the current entry issues if the entry is valid and that thread is ready; otherwise the cycle is a bubble.
- R5: An invalid active table entry always yields a bubble, whatever the ready flags are.
- R6: In `ST_READY`, the search for a ready thread starts at the thread after the last-issued one and moves upward, wrapping modulo NUM_THREADS. The first ready thread found issues. If no thread is ready, the cycle is a bubble.
- R7: The last-issued thread register is updated by every issue in any state. It is left unchanged by bubbles.
- R8: A write (`tbl_wr_en`=1) stores {`tbl_wr_valid`, `tbl_wr_tid`} into shadow entry `tbl_wr_idx`. The active table, which the issue logic uses, takes the whole shadow copy only at a commit point. A write made in the commit cycle itself is included.
- R9: `mode_sel` is sampled only at a commit point. Encoding: 0 selects `ST_FIXED`, 1 selects `ST_TABLE`, 2 selects `ST_READY`, 3 selects `ST_FIXED`. Both pointers restart at zero after every commit point.
- R10: `bubble` is always the inverse of `issue_valid`. `issue_tid` is 0 whenever no thread issues. An issued thread always has its ready bit set in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| thread_ready | input | NUM_THREADS | Bit t is 1 when thread t can issue this cycle |
| mode_sel | input | 2 | Requested scheduling mode, sampled at commit points |
| tbl_wr_en | input | 1 | Writes one shadow table entry |
| tbl_wr_idx | input | SLOT_W | Shadow entry index to write |
| tbl_wr_tid | input | TID_W | Thread named by the written entry |
| tbl_wr_valid | input | 1 | Valid bit of the written entry |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | TID_W | Issuing thread, 0 when none issues |
| bubble | output | 1 | This cycle is a pipeline bubble |

## Verification
Several input patterns drive the rotation. With all threads ready, the fixed rotation order is visible directly. With one thread stalled, a bubble can be told apart from a slot that is wrongly handed to a neighbour. With all threads stalled, the bench checks that the thread identifier reads zero. A sparse table is used that has an invalid entry and repeats some threads. Table writes are issued while a table rotation is running, which separates shadow timing from active timing. `mode_sel` is toggled in the middle of a rotation to show that it is sampled only at commit points. In the ready-driven state, patterns with a single ready thread and with none ready check the wrap-around start point. A fixed-mode stretch placed before a ready-mode stretch shows that issues in any state move the round-robin start. A long seeded random run then mixes all of these against a cycle-by-cycle model.

// File: rtl/bis_pkg.sv
package bis_pkg;

    typedef enum logic [1:0] {
        ST_FIXED = 2'd0,
        ST_TABLE = 2'd1,
        ST_READY = 2'd2
    } sched_state_e;

    // Mode request code to scheduler state; code 3 falls back to the fixed rotation.
    function automatic sched_state_e sel_to_state(input logic [1:0] sel);
        case (sel)
            2'd1:    return ST_TABLE;
            2'd2:    return ST_READY;
            default: return ST_FIXED;
        endcase
    endfunction

endpackage

// File: rtl/bis_wrap_ctr.sv
module bis_wrap_ctr #(
    parameter int LIMIT = 4,
    parameter int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic          at_last
);

    assign at_last = (count == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (step) begin
            count <= at_last ? '0 : count + 1'b1;
        end
    end

    // R2 / R4: a stepping pointer that is not at its end moves up by exactly one
    assert_ctr_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && !at_last) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/bis_slot_table.sv
module bis_slot_table #(
    parameter int NUM_SLOTS = 8,
    parameter int TID_W     = 2,
    parameter int SLOT_W    = 3,
    localparam int EW       = TID_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic              wr_valid,
    input  logic              commit,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [TID_W-1:0]  rd_tid,
    output logic              rd_valid
);

    logic [EW-1:0]           shadow_q [NUM_SLOTS];
    logic [EW-1:0]           active_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]    wr_hit;
    logic [NUM_SLOTS*EW-1:0] active_flat;
    logic [EW-1:0]           wr_word;

    assign wr_word = {wr_valid, wr_tid};

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_entry
        assign wr_hit[g]                  = wr_en && (wr_idx == SLOT_W'(g));
        assign active_flat[g*EW +: EW]    = active_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (wr_hit[i]) begin
                    shadow_q[i] <= wr_word;
                end
                if (commit) begin
                    active_q[i] <= wr_hit[i] ? wr_word : shadow_q[i];
                end
            end
        end
    end

    assign {rd_valid, rd_tid} = active_q[rd_idx];

    // R8: the table used for issue changes only across a commit point
    assert_table_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active_flat));

endmodule

// File: rtl/bis_rr_pick.sv
module bis_rr_pick #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0] req,
    input  logic [TID_W-1:0]       last,
    output logic                   grant_valid,
    output logic [TID_W-1:0]       grant_idx
);

    logic [TID_W-1:0] cand_idx [NUM_THREADS];

    // Candidate g is the thread g+1 places after the last issued one
    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_cand
        assign cand_idx[g] = TID_W'((int'(last) + g + 1) % NUM_THREADS);
    end

    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int k = NUM_THREADS - 1; k >= 0; k--) begin
            if (req[cand_idx[k]]) begin
                grant_valid = 1'b1;
                grant_idx   = cand_idx[k];
            end
        end
    end

    // R6: a grant always lands on a requesting thread
    always_comb begin
        if (grant_valid) begin
            assert_pick_ready_R6: assert (req[grant_idx]);
        end
    end

endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched
    import bis_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int NUM_SLOTS   = 8,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] thread_ready,
    input  logic [1:0]             mode_sel,
    input  logic                   tbl_wr_en,
    input  logic [SLOT_W-1:0]      tbl_wr_idx,
    input  logic [TID_W-1:0]       tbl_wr_tid,
    input  logic                   tbl_wr_valid,
    output logic                   issue_valid,
    output logic [TID_W-1:0]       issue_tid,
    output logic                   bubble
);

    sched_state_e      state_q, state_d;
    logic              commit;
    logic [TID_W-1:0]  rot_cnt;
    logic              rot_last;
    logic [SLOT_W-1:0] slot_cnt;
    logic              slot_last;
    logic [TID_W-1:0]  last_q;
    logic [TID_W-1:0]  tb_tid;
    logic              tb_valid;
    logic              pick_valid;
    logic [TID_W-1:0]  pick_idx;

    bis_wrap_ctr #(.LIMIT(NUM_THREADS), .CW(TID_W)) u_rot_ctr (
        .clk     (clk),
        .rst     (rst),
        .clear   (commit),
        .step    (state_q == ST_FIXED),
        .count   (rot_cnt),
        .at_last (rot_last)
    );

    bis_wrap_ctr #(.LIMIT(NUM_SLOTS), .CW(SLOT_W)) u_slot_ctr (
        .clk     (clk),
        .rst     (rst),
        .clear   (commit),
        .step    (state_q == ST_TABLE),
        .count   (slot_cnt),
        .at_last (slot_last)
    );

    bis_slot_table #(.NUM_SLOTS(NUM_SLOTS), .TID_W(TID_W), .SLOT_W(SLOT_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_wr_en),
        .wr_idx   (tbl_wr_idx),
        .wr_tid   (tbl_wr_tid),
        .wr_valid (tbl_wr_valid),
        .commit   (commit),
        .rd_idx   (slot_cnt),
        .rd_tid   (tb_tid),
        .rd_valid (tb_valid)
    );

    bis_rr_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_pick (
        .req         (thread_ready),
        .last        (last_q),
        .grant_valid (pick_valid),
        .grant_idx   (pick_idx)
    );

    // Commit point and next-state selection
    always_comb begin
        unique case (state_q)
            ST_FIXED: commit = rot_last;
            ST_TABLE: commit = slot_last;
            ST_READY: commit = 1'b1;
            default:  commit = 1'b1;
        endcase
        state_d = commit ? sel_to_state(mode_sel) : state_q;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FIXED;
        end else begin
            state_q <= state_d;
        end
    end

    // Last-issued thread for the round-robin start point
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= TID_W'(NUM_THREADS - 1);
        end else if (issue_valid) begin
            last_q <= issue_tid;
        end
    end

    // Outputs
    always_comb begin
        issue_valid = 1'b0;
        issue_tid   = '0;
        unique case (state_q)
            ST_FIXED: begin
                issue_valid = thread_ready[rot_cnt];
                issue_tid   = issue_valid ? rot_cnt : '0;
            end
            ST_TABLE: begin
                issue_valid = tb_valid && thread_ready[tb_tid];
                issue_tid   = issue_valid ? tb_tid : '0;
            end
            ST_READY: begin
                issue_valid = pick_valid;
                issue_tid   = pick_valid ? pick_idx : '0;
            end
            default: begin
                issue_valid = 1'b0;
                issue_tid   = '0;
            end
        endcase
        bubble = !issue_valid;
    end

    // R10: an issued thread is ready in that cycle
    assert_issue_ready_R10: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> thread_ready[issue_tid]);

    // R9: the state only moves across a commit point
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> (state_q == $past(state_q)));

    // R4: the table walk wraps to entry 0 after the last entry
    assert_slot_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TABLE && slot_last) |=> (slot_cnt == '0));

    // R1: the cycle after reset starts the fixed rotation at zero
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == ST_FIXED && rot_cnt == '0 && slot_cnt == '0));

endmodule

// File: tb/test_barrel_issue_sched.sv
module test_barrel_issue_sched;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int S  = 8;
    localparam int TW = 2;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  thread_ready = '0;
    logic [1:0]    mode_sel = 2'd0;
    logic          tbl_wr_en = 1'b0;
    logic [SW-1:0] tbl_wr_idx = '0;
    logic [TW-1:0] tbl_wr_tid = '0;
    logic          tbl_wr_valid = 1'b0;
    logic          issue_valid;
    logic [TW-1:0] issue_tid;
    logic          bubble;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state: 0 fixed, 1 table, 2 ready
    int          m_state, m_rot, m_slot, m_last;
    logic [TW:0] m_shadow [S];
    logic [TW:0] m_active [S];
    logic        exp_v;
    int          exp_tid;

    barrel_issue_sched #(.NUM_THREADS(N), .NUM_SLOTS(S)) i_barrel_issue_sched (
        .clk          (clk),
        .rst          (rst),
        .thread_ready (thread_ready),
        .mode_sel     (mode_sel),
        .tbl_wr_en    (tbl_wr_en),
        .tbl_wr_idx   (tbl_wr_idx),
        .tbl_wr_tid   (tbl_wr_tid),
        .tbl_wr_valid (tbl_wr_valid),
        .issue_valid  (issue_valid),
        .issue_tid    (issue_tid),
        .bubble       (bubble)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int decode_sel(input logic [1:0] s);
        if (s == 2'd1) return 1;
        if (s == 2'd2) return 2;
        return 0;
    endfunction

    function automatic void model_reset();
        m_state = 0; m_rot = 0; m_slot = 0; m_last = N - 1;
        for (int i = 0; i < S; i++) begin
            m_shadow[i] = '0;
            m_active[i] = '0;
        end
    endfunction

    function automatic void model_expect();
        exp_v = 1'b0; exp_tid = 0;
        if (m_state == 0) begin
            if (thread_ready[m_rot]) begin exp_v = 1'b1; exp_tid = m_rot; end
        end else if (m_state == 1) begin
            if (m_active[m_slot][TW] && thread_ready[m_active[m_slot][TW-1:0]]) begin
                exp_v = 1'b1; exp_tid = int'(m_active[m_slot][TW-1:0]);
            end
        end else begin
            for (int k = 1; k <= N; k++) begin
                if (!exp_v && thread_ready[(m_last + k) % N]) begin
                    exp_v = 1'b1; exp_tid = (m_last + k) % N;
                end
            end
        end
    endfunction

    function automatic void model_advance();
        logic commit;
        commit = (m_state == 0 && m_rot == N - 1) || (m_state == 1 && m_slot == S - 1) || (m_state == 2);
        if (tbl_wr_en) m_shadow[tbl_wr_idx] = {tbl_wr_valid, tbl_wr_tid};
        if (exp_v) m_last = exp_tid;
        if (commit) begin
            for (int i = 0; i < S; i++) m_active[i] = m_shadow[i];
            m_state = decode_sel(mode_sel);
            m_rot = 0; m_slot = 0;
        end else if (m_state == 0) begin
            m_rot++;
        end else if (m_state == 1) begin
            m_slot++;
        end
    endfunction

    function automatic string tag_of_state();
        if (m_state == 0) return "R2";
        if (m_state == 1) return "R4";
        return "R6";
    endfunction

    task automatic check(input string tag);
        model_expect();
        n_checks++;
        if (issue_valid !== exp_v || int'(issue_tid) != exp_tid || bubble !== !exp_v) begin
            n_fail++;
            $display("FAIL %s: valid/tid/bubble got %b/%0d/%b expected %b/%0d/%b",
                     tag, issue_valid, issue_tid, bubble, exp_v, exp_tid, !exp_v);
        end
    endtask

    // Inputs are already driven just after a falling edge; sample, then cross the rising edge
    task automatic tick(input string tag);
        #1;
        check(tag);
        model_advance();
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model_reset();
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [3:0] ready_seq [8];
        void'($urandom(32'd20240407));
        do_reset();

        // R1: first cycle after reset offers thread 0
        thread_ready = 4'b1111; mode_sel = 2'd0;
        tick("R1");
        // R2: full rotation with everyone ready
        for (int i = 0; i < 7; i++) tick("R2");
        // R3: thread 2 stalled gives bubbles in its slot only
        thread_ready = 4'b1011;
        for (int i = 0; i < 8; i++) tick("R3");
        // R10: all stalled, tid must read zero
        thread_ready = 4'b0000;
        for (int i = 0; i < 4; i++) tick("R10");
        // R9: request mid-rotation then withdraw before the wrap
        thread_ready = 4'b1111;
        mode_sel = 2'd1; tick("R9"); tick("R9");
        mode_sel = 2'd0; tick("R9"); tick("R9");
        // R9: held request is taken at the wrap
        mode_sel = 2'd1;
        for (int i = 0; i < 4; i++) tick("R9");
        // R5 / R1: table cleared by reset, so every slot is a bubble
        for (int i = 0; i < 8; i++) tick("R5");
        // R8: writes during a running table rotation stay in the shadow
        for (int i = 0; i < 8; i++) begin
            tbl_wr_en = 1'b1; tbl_wr_idx = SW'(i);
            tbl_wr_tid = TW'((i * 3) % N); tbl_wr_valid = (i != 5);
            tick("R8");
        end
        // R4 / R5: new table active after the wrap
        for (int i = 0; i < 8; i++) tick("R4");
        thread_ready = 4'b0101;
        for (int i = 0; i < 8; i++) tick("R4");
        // R6: move to ready mode at the slot wrap
        mode_sel = 2'd2; thread_ready = 4'b1111;
        for (int i = 0; i < 8; i++) tick("R6");
        ready_seq[0] = 4'b1111; ready_seq[1] = 4'b0000; ready_seq[2] = 4'b1010;
        ready_seq[3] = 4'b0110; ready_seq[4] = 4'b1000; ready_seq[5] = 4'b0001;
        ready_seq[6] = 4'b0001; ready_seq[7] = 4'b1111;
        for (int i = 0; i < 8; i++) begin
            thread_ready = ready_seq[i];
            tick("R6");
        end
        // R7: fixed-mode issues move the round-robin start point
        mode_sel = 2'd0; thread_ready = 4'b1111;
        tick("R7");
        mode_sel = 2'd2; thread_ready = 4'b0011;
        for (int i = 0; i < 4; i++) tick("R7");
        thread_ready = 4'b1111;
        tick("R7"); tick("R7");

        // Seeded random mix over all modes
        for (int i = 0; i < 3000; i++) begin
            thread_ready = N'($urandom);
            if ($urandom % 12 == 0) mode_sel = 2'($urandom);
            if ($urandom % 3 == 0) begin
                tbl_wr_en = 1'b1; tbl_wr_idx = SW'($urandom);
                tbl_wr_tid = TW'($urandom); tbl_wr_valid = ($urandom % 4 != 0);
            end
            tick(tag_of_state());
        end

        // R1: reset again with a populated table, then ask for the table
        do_reset();
        mode_sel = 2'd1; thread_ready = 4'b1111;
        for (int i = 0; i < 12; i++) tick("R1");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule